// File: doc/BRIEF.md
# SDRAM Bring-Up Sequencer

This block takes a single-data-rate SDRAM from power-up to normal operation. A caller provides the memory clock period and the device timings in nanoseconds, then pulses `start`. The block first turns those timings into clamped cycle-count fields of a controller configuration word, using six division units that run side by side. It then issues a precharge-all command and waits for a configurable settling time. Next it enables auto-refresh and starts a refresh interval counter, waits the same settling time again, and finally issues a mode register set. After that it raises `done`.

Commands leave on a plain abstract command bus, with one code per cycle and no back-pressure. Each command is implied to be taken in the cycle it is shown. The mode value appears on the address lines only in the mode-set cycle. Auto-refresh keeps running after `done`, so the refresh counter carries on into normal operation. The settling time is the parameter `WAIT_NS` (default 200000 ns). It is measured by adding the clock period on every cycle, so no division is needed for it.

Top module: `sdram_bringup_seq`

## Requirements
- R1: After reset the command bus shows NOP (code 0), `done` is low, and both the configuration word and the address bus are zero.
- R2: `start` is taken only while idle. PRECHARGE_ALL (code 1) appears in the single cycle that follows the (NS_W+2)th rising edge, counting the edge that samples `start` as the first. A `start` at any other time has no effect.
- R3: With K = ceil(WAIT_NS / period), exactly K NOP cycles follow the precharge-all before refresh is enabled. From that cycle, K more cycles pass before the mode-set slot.
- R4: Configuration bits [4:2] hold the tRAS cycle count minus 4. That count is floor(tRAS_ns/period), clamped to the range 4..11.
- R5: Bits [6:5] hold floor(tRCD_ns/period) capped at 3. Bits [9:7] hold floor(tRP_ns/period) capped at 7. Bits [11:10] hold floor(tWR_ns/period) capped at 3.
- R6: Bits [14:12] hold (n+1)>>1, where n = floor((tRAS_ns+tRP_ns)/period) capped at 14.
- R7: Bits [22:15] hold the refresh compare value. It is floor(floor(tREF_ns/period)/64)+1, saturated at 255. All fields are loaded in the precharge cycle and are zero before it.
- R8: Bit [23] is set from the first refresh-enabled cycle E onward. REFRESH (code 2) is issued at cycles E + 64·C·j for j ≥ 1, where C is the compare value, and this continues after `done`.
- R9: Bits [1:0] hold the latency code, 1 for CAS latency 2 and 2 for latency 3. In the mode-set cycle the address bus carries the mode value shifted left by 1 when `bus32` is 0 and by 2 when it is 1. The mode value has burst length 4 (bits [2:0]=010), sequential burst (bit 3=0), CAS latency in bits [6:4] and normal mode (bits [8:7]=0). The address bus is zero in every other cycle.
- R10: MRS (code 3) is issued once in the mode-set slot. If a REFRESH falls in that slot, the MRS moves to the next cycle. Bit [24] is set from the mode-set slot onward. `done` rises in the cycle after the MRS and stays high until reset.
- R11: Every cycle that carries none of the commands above shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the sequence when idle |
| period_ns | input | PER_W | Memory clock period in ns, nonzero |
| tras_ns | input | NS_W | Active-to-precharge time |
| trcd_ns | input | NS_W | Activate-to-column time |
| trp_ns | input | NS_W | Precharge time |
| twr_ns | input | NS_W | Write recovery time |
| tref_ns | input | NS_W | Refresh interval base time |
| cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| bus32 | input | 1 | 1 for a 32-bit data bus, 0 for 16-bit |
| cmd_o | output | 2 | Command: 0 NOP, 1 PRECHARGE_ALL, 2 REFRESH, 3 MRS |
| maddr_o | output | ADDR_W | Address lines carrying the mode value |
| cfg_o | output | 25 | Controller configuration word |
| done_o | output | 1 | Initialization complete |

## Verification
The in-line assertions check, on every cycle, that:
- `done` never falls once set and rises only right after an MRS;
- the address bus is quiet outside MRS;
- precharge-all only happens with refresh off, and MRS only with it on;
- the configuration word is frozen after completion;
- refresh pulses are single cycles issued only while enabled.

Only the bench's scenarios can show the numeric side: the clamped and capped field values, the exact wait lengths for several periods, the refresh spacing for different compare values, the saturated compare, and the one-cycle deferral of MRS when it meets a refresh.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PALL = 2'd1,
    CMD_REF  = 2'd2,
    CMD_MRS  = 2'd3
  } mem_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_PALL,
    ST_WAIT1,
    ST_WAIT2,
    ST_MRS,
    ST_DONE
  } seq_state_e;

  // Controller configuration word, most significant field first.
  typedef struct packed {
    logic       mset;   // [24] mode-set enabled
    logic       rfsh;   // [23] auto-refresh enabled
    logic [7:0] rcmp;   // [22:15] refresh compare
    logic [2:0] trc;    // [14:12] row cycle code
    logic [1:0] twr;    // [11:10] write recovery
    logic [2:0] trp;    // [9:7] precharge
    logic [1:0] trcd;   // [6:5] ras-to-cas
    logic [2:0] tras;   // [4:2] tras minus 4
    logic [1:0] cl;     // [1:0] latency code
  } cfg_word_t;

  localparam int CFG_W = $bits(cfg_word_t);
  localparam int MODE_W = 9;
  localparam logic [2:0] BURST4_CODE = 3'b010;

endpackage

// File: rtl/seq_div.sv
module seq_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = shifted >= {1'b0, den_q};
    diff    = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= num;
      den_q <= den;
      cnt_q <= CW'(W);
    end else if (cnt_q != '0) begin
      rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo  = quo_q;
  assign busy = (cnt_q != '0);

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(quo));

endmodule

// File: rtl/timing_field_enc.sv
module timing_field_enc
  import sdram_init_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] q_ras,
  input  logic [W-1:0] q_rcd,
  input  logic [W-1:0] q_rp,
  input  logic [W-1:0] q_wr,
  input  logic [W-1:0] q_rc,
  input  logic [W-1:0] q_ref,
  input  logic         cas3,
  output cfg_word_t    enc_o
);
  logic [W-1:0] ras_off;
  logic [3:0]   rc_n;
  logic [4:0]   rc_np1;
  logic [W-1:0] ref_blk;

  always_comb begin
    enc_o      = '0;
    enc_o.cl   = cas3 ? 2'd2 : 2'd1;

    ras_off = q_ras - W'(4);
    if (q_ras < W'(4))       enc_o.tras = 3'd0;
    else if (q_ras > W'(11)) enc_o.tras = 3'd7;
    else                     enc_o.tras = ras_off[2:0];

    enc_o.trcd = (q_rcd > W'(3)) ? 2'd3 : q_rcd[1:0];
    enc_o.trp  = (q_rp  > W'(7)) ? 3'd7 : q_rp[2:0];
    enc_o.twr  = (q_wr  > W'(3)) ? 2'd3 : q_wr[1:0];

    rc_n      = (q_rc > W'(14)) ? 4'd14 : q_rc[3:0];
    rc_np1    = {1'b0, rc_n} + 5'd1;
    enc_o.trc = rc_np1[3:1];

    ref_blk = q_ref >> 6;
    if (ref_blk >= W'(255)) enc_o.rcmp = 8'hFF;
    else                    enc_o.rcmp = ref_blk[7:0] + 8'd1;
  end

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int PRESC_W = 6,
  parameter int CMP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CMP_W-1:0] cmp,
  output logic             fire
);
  logic [PRESC_W-1:0] presc_q;
  logic [CMP_W-1:0]   cnt_q;
  logic               fire_q;
  logic               tick;

  assign tick = en && (presc_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      presc_q <= '0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      presc_q <= presc_q + 1'b1;
      fire_q  <= 1'b0;
      if (tick) begin
        if (cnt_q == CMP_W'(cmp - 1'b1)) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire = fire_q;

  // R8
  refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R8
  fire_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> en);

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdram_init_pkg::*;
#(
  parameter int NS_W    = 32,
  parameter int PER_W   = 8,
  parameter int ADDR_W  = 13,
  parameter int WAIT_NS = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PER_W-1:0]  period_ns,
  input  logic [NS_W-1:0]   tras_ns,
  input  logic [NS_W-1:0]   trcd_ns,
  input  logic [NS_W-1:0]   trp_ns,
  input  logic [NS_W-1:0]   twr_ns,
  input  logic [NS_W-1:0]   tref_ns,
  input  logic              cas3,
  input  logic              bus32,
  output logic [1:0]        cmd_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [24:0]       cfg_o,
  output logic              done_o
);
  localparam int NJOB  = 6;
  localparam int ACC_W = $clog2(WAIT_NS + (1 << PER_W)) + 1;

  seq_state_e       state_q;
  cfg_word_t        cfg_q;
  cfg_word_t        enc_w;
  logic             rfsh_en_q;
  logic             cas3_q, bus32_q;
  logic [PER_W-1:0] period_q;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic             wait_hit;
  logic             load;
  logic             fire;
  mem_cmd_e         cmd_w;

  logic [NS_W-1:0]  div_num [NJOB];
  logic [NS_W-1:0]  div_quo [NJOB];
  logic [NJOB-1:0]  div_busy;

  assign load = start && (state_q == ST_IDLE);

  assign div_num[0] = tras_ns;
  assign div_num[1] = trcd_ns;
  assign div_num[2] = trp_ns;
  assign div_num[3] = twr_ns;
  assign div_num[4] = tras_ns + trp_ns;
  assign div_num[5] = tref_ns;

  for (genvar g = 0; g < NJOB; g++) begin : g_div
    seq_div #(.W(NS_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .num  (div_num[g]),
      .den  (NS_W'(period_ns)),
      .quo  (div_quo[g]),
      .busy (div_busy[g])
    );
  end

  timing_field_enc #(.W(NS_W)) u_enc (
    .q_ras(div_quo[0]),
    .q_rcd(div_quo[1]),
    .q_rp (div_quo[2]),
    .q_wr (div_quo[3]),
    .q_rc (div_quo[4]),
    .q_ref(div_quo[5]),
    .cas3 (cas3_q),
    .enc_o(enc_w)
  );

  refresh_timer #(.PRESC_W(6), .CMP_W(8)) u_rfsh (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (rfsh_en_q),
    .cmp  (cfg_q.rcmp),
    .fire (fire)
  );

  assign acc_nxt  = acc_q + ACC_W'(period_q);
  assign wait_hit = acc_nxt >= ACC_W'(WAIT_NS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      rfsh_en_q <= 1'b0;
      cas3_q    <= 1'b0;
      bus32_q   <= 1'b0;
      period_q  <= '0;
      acc_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_CALC;
          cas3_q   <= cas3;
          bus32_q  <= bus32;
          period_q <= period_ns;
        end
        ST_CALC: if (div_busy == '0) begin
          state_q <= ST_PALL;
          cfg_q   <= enc_w;
        end
        ST_PALL: begin
          state_q <= ST_WAIT1;
          acc_q   <= '0;
        end
        ST_WAIT1: begin
          if (wait_hit) begin
            state_q    <= ST_WAIT2;
            acc_q      <= '0;
            rfsh_en_q  <= 1'b1;
            cfg_q.rfsh <= 1'b1;
          end else begin
            acc_q <= acc_nxt;
          end
        end
        ST_WAIT2: begin
          if (wait_hit) begin
            state_q    <= ST_MRS;
            cfg_q.mset <= 1'b1;
          end else begin
            acc_q <= acc_nxt;
          end
        end
        ST_MRS: if (!fire) state_q <= ST_DONE;
        default: state_q <= state_q;
      endcase
    end
  end

  always_comb begin
    if (fire) cmd_w = CMD_REF;
    else begin
      case (state_q)
        ST_PALL: cmd_w = CMD_PALL;
        ST_MRS:  cmd_w = CMD_MRS;
        default: cmd_w = CMD_NOP;
      endcase
    end
  end

  logic [MODE_W-1:0] mode_val;
  assign mode_val = {2'b00, (cas3_q ? 3'd3 : 3'd2), 1'b0, BURST4_CODE};

  assign cmd_o   = cmd_w;
  assign maddr_o = (state_q == ST_MRS && !fire)
                   ? (ADDR_W'(mode_val) << (bus32_q ? 2 : 1)) : '0;
  assign cfg_o   = cfg_q;
  assign done_o  = (state_q == ST_DONE);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(cmd_o) == CMD_MRS));

  // R9
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_MRS) |-> (maddr_o == '0));

  // R3
  pall_no_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PALL) |-> !rfsh_en_q);

  // R8
  mrs_after_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (rfsh_en_q && cfg_o[23]));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $stable(cfg_o));

endmodule

// File: tb/sim_sdram_bringup_seq.sv
`timescale 1ns/1ps
module sim_sdram_bringup_seq;
  localparam int WAIT = 320;
  localparam int NSW  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  period_ns = 8'd5;
  logic [31:0] tras_ns = '0, trcd_ns = '0, trp_ns = '0, twr_ns = '0, tref_ns = '0;
  logic        cas3 = 1'b0, bus32 = 1'b0;
  logic [1:0]  cmd_o;
  logic [12:0] maddr_o;
  logic [24:0] cfg_o;
  logic        done_o;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdram_bringup_seq #(.NS_W(NSW), .PER_W(8), .ADDR_W(13), .WAIT_NS(WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ns(period_ns),
    .tras_ns(tras_ns), .trcd_ns(trcd_ns), .trp_ns(trp_ns), .twr_ns(twr_ns),
    .tref_ns(tref_ns), .cas3(cas3), .bus32(bus32),
    .cmd_o(cmd_o), .maddr_o(maddr_o), .cfg_o(cfg_o), .done_o(done_o)
  );

  task automatic check(input string tag, input int act, input int exp, input int n);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got 0x%0h expected 0x%0h", tag, n, act, exp);
    end
  endtask

  // R1: reset state
  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check("R1 cmd", int'(cmd_o), 0, -1);
      check("R1 done", int'(done_o), 0, -1);
      check("R1 cfg", int'(cfg_o), 0, -1);
      check("R1 addr", int'(maddr_o), 0, -1);
    end
  endtask

  task automatic run_case(input int p, input int ras, input int rcd, input int rp,
                          input int wr, input int rf, input bit c3, input bit b32);
    int q, f_ras, f_rcd, f_rp, f_wr, f_rc, cmpv, cl, base, mode, addr;
    int kw, pn, en_c, ms_slot, mrs_n, last;
    do_reset();
    // expected fields from the requirement arithmetic
    q = ras / p; if (q < 4) q = 4; if (q > 11) q = 11; f_ras = q - 4;      // R4
    f_rcd = rcd / p; if (f_rcd > 3) f_rcd = 3;                              // R5
    f_rp  = rp / p;  if (f_rp > 7)  f_rp = 7;
    f_wr  = wr / p;  if (f_wr > 3)  f_wr = 3;
    q = (ras + rp) / p; if (q > 14) q = 14; f_rc = (q + 1) >> 1;            // R6
    cmpv = (rf / p) / 64 + 1; if (cmpv > 255) cmpv = 255;                   // R7
    cl = c3 ? 2 : 1;                                                        // R9
    base = cl | (f_ras << 2) | (f_rcd << 5) | (f_rp << 7) | (f_wr << 10)
         | (f_rc << 12) | (cmpv << 15);
    mode = 2 | ((c3 ? 3 : 2) << 4);
    addr = mode << (b32 ? 2 : 1);
    kw = (WAIT + p - 1) / p;                                                // R3
    pn = NSW + 1;
    en_c = pn + 1 + kw;
    ms_slot = en_c + kw;
    mrs_n = ((ms_slot - en_c) % (64 * cmpv) == 0) ? ms_slot + 1 : ms_slot;  // R10
    last = mrs_n + 300;

    @(negedge clk);
    period_ns = 8'(p); tras_ns = ras; trcd_ns = rcd; trp_ns = rp;
    twr_ns = wr; tref_ns = rf; cas3 = c3; bus32 = b32;
    start = 1'b1;
    for (int n = 0; n <= last; n++) begin
      int e_cmd, e_cfg;
      string tg;
      @(negedge clk);
      // R2: stray start pulses inside the run must change nothing
      start = (n == pn + 5) || (n == mrs_n + 5);
      if (n > en_c && ((n - en_c) % (64 * cmpv)) == 0) begin e_cmd = 2; tg = "R8 cmd"; end
      else if (n == pn) begin e_cmd = 1; tg = "R2 cmd"; end
      else if (n == mrs_n) begin e_cmd = 3; tg = "R10 cmd"; end
      else if (n > pn && n < ms_slot) begin e_cmd = 0; tg = "R3 cmd"; end
      else begin e_cmd = 0; tg = "R11 cmd"; end
      check(tg, int'(cmd_o), e_cmd, n);
      check("R10 done", int'(done_o), (n > mrs_n) ? 1 : 0, n);
      check("R9 addr", int'(maddr_o), (n == mrs_n) ? addr : 0, n);
      if (n < pn) e_cfg = 0;
      else e_cfg = base | ((n >= en_c) ? (1 << 23) : 0) | ((n >= ms_slot) ? (1 << 24) : 0);
      check("R4 R5 R6 R7 cfg", int'(cfg_o), e_cfg, n);
    end
    start = 1'b0;
  endtask

  initial begin
    // collision: wait is 64 cycles, compare 1, MRS deferred
    run_case(5, 45, 20, 20, 15, 100, 1'b0, 1'b0);
    // low tRAS clamp, caps on precharge and write recovery, compare 4
    run_case(10, 20, 5, 100, 50, 2000, 1'b1, 1'b1);
    // high tRAS clamp, row-cycle cap, saturated compare
    run_case(7, 200, 21, 14, 7, 64000000, 1'b1, 1'b0);
    // short period, long wait, compare 3
    run_case(3, 12, 9, 21, 6, 384, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule